// File: doc/BRIEF.md
# Stereo PCM Serial Output Port

This block moves one left and one right PCM sample per frame onto a single serial data line. Samples arrive as parallel words with a valid strobe. The block watches a bit clock and a frame clock, all sampled on the fast system clock. It places each word MSB first in the half frame for its channel. In master mode the two serial clocks come from a local generator. In slave mode they arrive from outside and first pass through a synchronizer.

Three format pins are latched while reset is high and frozen afterwards. The first picks master or slave, and its latched value drives the direction control for the external clock pins. The second picks I2S or left-justified framing. The third asks for short 16-bit words with 16 bit clocks per half frame; it takes effect in slave mode only. After reset is released the data line stays low for a fixed number of frames. Real data then starts at a frame boundary.

Top module: `pcm_serial_tx`

## Requirements
- R1: While `rst` is high, `clk_pins_out` is 0. After release it equals the value `fmt_master` had during reset: 1 means master, so the clock pins are outputs, and 0 means slave.
- R2: While `rst` is high, and on the first cycle after release, `sdo` is 0.
- R3: Changes on `fmt_master`, `fmt_ljust` or `fmt_short` after reset release have no effect on `clk_pins_out` or on the framing until the next reset.
- R4: Left-channel half-frame starts are counted from reset release. `sdo` stays 0 until the START_FRAMES-th one (default 136). From that frame on, both channels carry sample data.
- R5: When `fmt_ljust`=0 (I2S), the left channel occupies the half frame where the frame clock is low. Its MSB is driven on the second bit-clock falling edge of that half frame, one bit clock after the frame-clock edge.
- R6: When `fmt_ljust`=1 (left-justified), the left channel occupies the half frame where the frame clock is high. Its MSB is driven on the bit-clock falling edge that coincides with the frame-clock edge.
- R7: `sdo` changes only after a bit-clock falling edge. Bits are sent MSB first, and every slot position past the word length is 0.
- R8: In master mode, 24-bit words with 32 bit clocks per half frame are used whatever `fmt_short` says.
- R9: In slave mode with `fmt_short`=1, each half frame has 16 bit clocks and carries bits 23..8 of the sample. In I2S framing the LSB of one channel falls on the first bit clock of the next half frame.
- R10: The sample pair last written with `sample_vld` before a left half-frame start is the one sent in that frame. A write later in that frame does not alter its right half.
- R11: Only the selected clock source is used. The local generator inputs are ignored in slave mode, and the external clock inputs are ignored in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; format pins are captured while high |
| fmt_master | input | 1 | 1 = master (clocks from local generator), 0 = slave |
| fmt_ljust | input | 1 | 1 = left-justified, 0 = I2S |
| fmt_short | input | 1 | 1 = 16-bit words in 16-clock half frames (slave only) |
| sample_l | input | 24 | Left channel sample |
| sample_r | input | 24 | Right channel sample |
| sample_vld | input | 1 | Writes both samples into the holding registers |
| ext_bck | input | 1 | External bit clock (slave) |
| ext_lrck | input | 1 | External frame clock (slave) |
| gen_bck | input | 1 | Local generator bit clock (master) |
| gen_lrck | input | 1 | Local generator frame clock (master) |
| sdo | output | 1 | Serial data line |
| clk_pins_out | output | 1 | 1 = drive the bit and frame clock pins as outputs |

## Verification
The bench checks bit positions around the frame-clock edge in every framing. An off-by-one in the I2S delay, or a wrong left level, would show as a shifted or swapped word. The short slave mode is checked for the carried LSB; a design that dropped it would leave the first bit of each half frame at 0. The mute window is checked frame by frame, so a counter that opens one frame early or late shows data in a muted frame or zeros in the first live one. Format pins are toggled mid-run and samples are rewritten inside a frame, to catch a design that reacts to either before the proper boundary.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    typedef struct packed {
        logic master;
        logic ljust;
        logic short16;
    } tx_cfg_t;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // Frame clock level that marks the left half frame.
    function automatic logic left_level(input tx_cfg_t c);
        return c.ljust;
    endfunction

    // Short words are a slave-only option.
    function automatic logic use_short(input tx_cfg_t c);
        return c.short16 & ~c.master;
    endfunction

endpackage

// File: rtl/pcm_tx_sync.sv
module pcm_tx_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [WIDTH-1:0] stg [STAGES];
            always_ff @(posedge clk) stg[0] <= d;
            for (genvar i = 1; i < STAGES; i++) begin : g_stage
                always_ff @(posedge clk) stg[i] <= stg[i-1];
            end
            assign q = stg[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pcm_tx_edge.sv
module pcm_tx_edge (
    input  logic clk,
    input  logic rst,
    input  logic bck,
    input  logic lrck,
    output logic bck_fall,
    output logic half_start
);
    logic bck_q;
    logic lr_seen;

    assign bck_fall   = bck_q & ~bck;
    assign half_start = bck_fall & (lrck != lr_seen);

    always_ff @(posedge clk) begin
        bck_q <= bck;
        if (rst)
            lr_seen <= lrck;
        else if (bck_fall)
            lr_seen <= lrck;
    end
endmodule

// File: rtl/pcm_tx_cfg.sv
module pcm_tx_cfg
    import pcm_tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tx_cfg_t pins,
    output tx_cfg_t cfg,
    output logic    dir_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= pins;
            dir_out <= 1'b0;
        end else begin
            dir_out <= cfg.master;
        end
    end
endmodule

// File: rtl/pcm_tx_gate.sv
module pcm_tx_gate #(
    parameter int START_FRAMES = 136
) (
    input  logic clk,
    input  logic rst,
    input  logic left_start,
    output logic open_now,
    output logic live
);
    localparam int CW = $clog2(START_FRAMES + 1);
    localparam logic [CW-1:0] LAST = CW'(START_FRAMES - 1);

    logic [CW-1:0] cnt;

    assign open_now = live | (left_start && cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            live <= 1'b0;
        end else if (left_start && !live) begin
            cnt <= cnt + CW'(1);
            if (cnt == LAST)
                live <= 1'b1;
        end
    end
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SHORT_W  = 16,
    parameter int SLOT_W   = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  tx_cfg_t             cfg,
    input  logic [SAMPLE_W-1:0] sample_l,
    input  logic [SAMPLE_W-1:0] sample_r,
    input  logic                sample_vld,
    input  logic                bck_fall,
    input  logic                half_start,
    input  chan_e               chan,
    input  logic                open_now,
    output logic                sdo
);
    localparam int PAD_LONG  = SLOT_W - SAMPLE_W;
    localparam int PAD_SHORT = SLOT_W - SHORT_W;

    function automatic logic [SLOT_W-1:0] align(input logic [SAMPLE_W-1:0] w,
                                                input logic s);
        if (s)
            return {w[SAMPLE_W-1 -: SHORT_W], {PAD_SHORT{1'b0}}};
        return {w, {PAD_LONG{1'b0}}};
    endfunction

    logic [SAMPLE_W-1:0] hold_l, hold_r, frame_r;
    logic [SLOT_W-1:0]   sr, load_vec;
    logic                pend, stream_bit;

    assign load_vec   = open_now
                      ? align((chan == CH_LEFT) ? hold_l : frame_r, use_short(cfg))
                      : '0;
    assign stream_bit = half_start ? load_vec[SLOT_W-1] : sr[SLOT_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_l  <= '0;
            hold_r  <= '0;
            frame_r <= '0;
            sr      <= '0;
            pend    <= 1'b0;
            sdo     <= 1'b0;
        end else begin
            if (sample_vld) begin
                hold_l <= sample_l;
                hold_r <= sample_r;
            end
            if (half_start && chan == CH_LEFT)
                frame_r <= hold_r;
            if (bck_fall) begin
                sr <= half_start ? (load_vec << 1) : (sr << 1);
                if (cfg.ljust) begin
                    sdo <= stream_bit;
                end else begin
                    sdo  <= pend;
                    pend <= stream_bit;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W     = 24,
    parameter int SHORT_W      = 16,
    parameter int SLOT_W       = 32,
    parameter int START_FRAMES = 136,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fmt_master,
    input  logic                fmt_ljust,
    input  logic                fmt_short,
    input  logic [SAMPLE_W-1:0] sample_l,
    input  logic [SAMPLE_W-1:0] sample_r,
    input  logic                sample_vld,
    input  logic                ext_bck,
    input  logic                ext_lrck,
    input  logic                gen_bck,
    input  logic                gen_lrck,
    output logic                sdo,
    output logic                clk_pins_out
);
    tx_cfg_t    cfg;
    logic [1:0] ext_sync;
    logic       bck_sel, lr_sel;
    logic       bck_fall, half_start, open_now, live;
    chan_e      chan;

    pcm_tx_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .pins    ('{master: fmt_master, ljust: fmt_ljust, short16: fmt_short}),
        .cfg     (cfg),
        .dir_out (clk_pins_out)
    );

    pcm_tx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk (clk),
        .d   ({ext_bck, ext_lrck}),
        .q   (ext_sync)
    );

    assign bck_sel = cfg.master ? gen_bck  : ext_sync[1];
    assign lr_sel  = cfg.master ? gen_lrck : ext_sync[0];
    assign chan    = (lr_sel == left_level(cfg)) ? CH_LEFT : CH_RIGHT;

    pcm_tx_edge u_edge (
        .clk        (clk),
        .rst        (rst),
        .bck        (bck_sel),
        .lrck       (lr_sel),
        .bck_fall   (bck_fall),
        .half_start (half_start)
    );

    pcm_tx_gate #(.START_FRAMES(START_FRAMES)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .left_start (half_start && chan == CH_LEFT),
        .open_now   (open_now),
        .live       (live)
    );

    pcm_tx_shift #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W), .SLOT_W(SLOT_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .sample_l   (sample_l),
        .sample_r   (sample_r),
        .sample_vld (sample_vld),
        .bck_fall   (bck_fall),
        .half_start (half_start),
        .chan       (chan),
        .open_now   (open_now),
        .sdo        (sdo)
    );
endmodule

// File: rtl/pcm_tx_chk.sv
module pcm_tx_chk (
    input logic clk,
    input logic rst,
    input logic sdo,
    input logic clk_pins_out,
    input logic live,
    input logic bck_fall
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!sdo && !clk_pins_out)); // R2

    AST_DIR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> $stable(clk_pins_out)); // R3

    AST_MUTED_LOW: assert property (@(posedge clk) disable iff (rst)
        !live |-> !sdo); // R4

    AST_LIVE_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(live) |-> live); // R4

    AST_SDO_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo) |-> $past(bck_fall)); // R7
endmodule

bind pcm_serial_tx pcm_tx_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .sdo          (sdo),
    .clk_pins_out (clk_pins_out),
    .live         (live),
    .bck_fall     (bck_fall)
);

// File: tb/pcm_serial_tx_tb_top.sv
module pcm_serial_tx_tb_top;

    localparam int START = 3;

    typedef struct packed {
        logic        m;
        logic        lj;
        logic        sh;
        logic [23:0] l;
        logic [23:0] r;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 24'hA5C3F1, 24'h3C0F81},  // slave I2S 24
        '{1'b0, 1'b1, 1'b0, 24'h812345, 24'hF0F00F},  // slave LJ 24
        '{1'b1, 1'b0, 1'b0, 24'hC0FFEE, 24'h5A5A5B},  // master I2S
        '{1'b1, 1'b1, 1'b1, 24'h9E3701, 24'h13579B},  // master LJ, short pin ignored
        '{1'b0, 1'b0, 1'b1, 24'hB4D3E1, 24'h6F0281},  // slave I2S 16
        '{1'b0, 1'b1, 1'b1, 24'hE00F37, 24'h8001FF}   // slave LJ 16
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fmt_master = 1'b0, fmt_ljust = 1'b0, fmt_short = 1'b0;
    logic [23:0] sample_l = '0, sample_r = '0;
    logic sample_vld = 1'b0;
    logic ext_bck = 1'b0, ext_lrck = 1'b0, gen_bck = 1'b0, gen_lrck = 1'b0;
    logic sdo, clk_pins_out;

    int checks = 0;
    int failures = 0;
    logic cur_m, cur_lj, cur_sh;
    logic [23:0] prev_word;

    always #4 clk = ~clk;

    pcm_serial_tx #(.START_FRAMES(START)) dut_i (
        .clk (clk), .rst (rst),
        .fmt_master (fmt_master), .fmt_ljust (fmt_ljust), .fmt_short (fmt_short),
        .sample_l (sample_l), .sample_r (sample_r), .sample_vld (sample_vld),
        .ext_bck (ext_bck), .ext_lrck (ext_lrck), .gen_bck (gen_bck), .gen_lrck (gen_lrck),
        .sdo (sdo), .clk_pins_out (clk_pins_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // R11: only the selected source toggles; the other stays at 0.
    task automatic drive(input logic b, input logic lv);
        if (cur_m) begin gen_bck = b; gen_lrck = lv; end
        else begin ext_bck = b; ext_lrck = lv; end
    endtask

    task automatic do_reset(input vec_t v);
        @(negedge clk);
        cur_m = v.m; cur_lj = v.lj; cur_sh = v.sh;
        fmt_master = v.m; fmt_ljust = v.lj; fmt_short = v.sh;
        rst = 1'b1;
        ext_bck = 1'b0; ext_lrck = 1'b0; gen_bck = 1'b0; gen_lrck = 1'b0;
        drive(1'b1, ~v.lj);
        prev_word = '0;
        repeat (5) @(negedge clk);
        check("R2 sdo low in reset", {31'b0, sdo}, 32'h0);
        check("R1 clock pins input in reset", {31'b0, clk_pins_out}, 32'h0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 direction after release", {31'b0, clk_pins_out}, {31'b0, v.m});
    endtask

    task automatic run_frame(input logic [23:0] l, input logic [23:0] r,
                             input bit live, input bit mid_upd, input string tag);
        logic        eff_sh;
        int          half, wl, k;
        logic [31:0] got, exp;
        logic [23:0] word;
        logic        lvl;
        eff_sh = cur_sh & ~cur_m;
        half   = eff_sh ? 16 : 32;
        wl     = eff_sh ? 16 : 24;
        @(negedge clk);
        sample_l = l; sample_r = r; sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
        for (int ch = 0; ch < 2; ch++) begin
            got = '0; exp = '0;
            word = (ch == 0) ? l : r;
            if (eff_sh) word = {8'h00, word[23:8]};
            if (!live) word = '0;
            lvl = (ch == 0) ? cur_lj : ~cur_lj;
            for (int p = 0; p < half; p++) begin
                @(negedge clk);
                drive(1'b0, lvl);
                if (mid_upd && ch == 0 && p == 4) begin
                    sample_l = ~l; sample_r = ~r; sample_vld = 1'b1;
                    @(negedge clk);
                    sample_vld = 1'b0;
                    repeat (6) @(negedge clk);
                end else begin
                    repeat (7) @(negedge clk);
                end
                got[p] = sdo;
                drive(1'b1, lvl);
                repeat (7) @(negedge clk);
            end
            for (int p = 0; p < half; p++) begin
                k = cur_lj ? p : p - 1;
                if (k < 0)
                    exp[p] = (half - 1 < wl) ? prev_word[wl - half] : 1'b0;
                else
                    exp[p] = (k < wl) ? word[wl - 1 - k] : 1'b0;
            end
            prev_word = word;
            check($sformatf("%s ch%0d", tag, ch), got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string fmt_tag;
            v = VECS[i];
            fmt_tag = v.m ? (v.sh ? "R8 R6 master short ignored" : (v.lj ? "R8 R6" : "R8 R5"))
                          : (v.sh ? (v.lj ? "R9 R6" : "R9 R5") : (v.lj ? "R6 R7" : "R5 R7"));
            do_reset(v);
            run_frame(v.l, v.r, 1'b0, 1'b0, "R4 muted frame 1");
            run_frame(v.r, v.l, 1'b0, 1'b0, "R4 muted frame 2");
            run_frame(v.l, v.r, 1'b1, 1'b0, {fmt_tag, " R4 first live frame"});
            // R3: pins flipped after release must change nothing
            @(negedge clk);
            fmt_master = ~v.m; fmt_ljust = ~v.lj; fmt_short = ~v.sh;
            repeat (3) @(negedge clk);
            check("R3 direction frozen", {31'b0, clk_pins_out}, {31'b0, v.m});
            run_frame(v.l ^ 24'h5AA5C3, v.r ^ 24'h0FF0F0, 1'b1, 1'b1,
                      {fmt_tag, " R3 R10 R11 pins changed, mid-frame write"});
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule